// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a 24-bit CPU address into a physical DRAM address using a map made of 64 KB segments. The map has three kinds of region. The low base memory is identity mapped. A high shadow region at the top of the space aliases the lowest physical segments. A set of memory-bank windows each places a run of physical segments at a virtual start segment chosen by configuration. The segment number is the top eight address bits, and the offset is the low sixteen bits.

The configuration is captured in one clock edge when `cfg_load` is high. The translation itself is purely combinational from the captured configuration and the current access. An access hits when its segment is mapped and its translated address lies below the installed memory size. A mapped read that lands beyond installed memory returns an all-ones pattern of the access width instead of hitting. A write is further gated by a write-protect control that covers the relocated segments and the top two segments. An invalid pair of configuration codes raises an error flag and maps nothing.

Top module: `memwin_xlate`

## Requirements
- R1: Base-memory code selects the identity-mapped low segments: code 2'b00 maps segments 0x00 to 0x09, 2'b10 maps 0x00 to 0x07, 2'b11 maps 0x00 to 0x03; on those segments the physical address equals the CPU address.
- R2: The high region runs from a start segment up to 0xFF and maps each segment to the physical segment given by its low four bits, offset unchanged. The start is 0xFA when the base code is 2'b00 or the first bank code is 2'b01; otherwise it is 0xF8 for base code 2'b10 and 0xF4 for base code 2'b11.
- R3: When `cfg_relo_ram` was captured high, segments 0x0E and 0x0F are identity mapped; when it was captured low they are not mapped by this rule.
- R4: Bank i (field bits [2i+1:2i] of `cfg_bank_codes`) holds 64 segments for code 2'b01, 16 for 2'b10 and none for 2'b00 or 2'b11; bank 0 holds 16 fewer (never below zero). Physical start segments accumulate from 0x10 upward in bank order. A CPU address in bank i's window (start segment from bits [8i+7:8i] of `cfg_win_vbase`) translates to address minus window start plus physical start.
- R5: A mapped access whose physical segment is at or above `cfg_mem_segs` does not hit; if it is a read, `rd_blank` is high and `blank_data` is 0xFF for size 2'b00, 0xFFFF for 2'b01 and 0xFFFFFFFF for 2'b10 or 2'b11. Writes beyond memory produce neither a hit nor a blank.
- R6: `wr_en` is high only for a hitting write; when `cfg_wp` was captured high, writes to segments 0x0E, 0x0F, 0xFE and 0xFF still hit but give no write enable.
- R7: Base code 2'b01, or a first bank code other than 2'b01 or 2'b10, raises `cfg_err` and suppresses every hit and blank.
- R8: After reset nothing is mapped and `cfg_err` is low; configuration inputs affect the map only on a clock edge with `cfg_load` high.
- R9: Priority is low base memory, then the relocated pair, then the high region, then the bank windows in ascending index; an overlapping window with a lower index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture all configuration inputs on this edge |
| cfg_base_code | input | 2 | Base-memory size code |
| cfg_bank_codes | input | 2*NBANK | Two-bit size code per bank, bank 0 in the low bits |
| cfg_win_vbase | input | 8*NBANK | Virtual start segment per bank window |
| cfg_relo_ram | input | 1 | Segments 0x0E/0x0F act as RAM |
| cfg_wp | input | 1 | Write-protect the relocated and top two segments |
| cfg_mem_segs | input | 9 | Installed memory size in 64 KB segments |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 24 | CPU address |
| acc_size | input | 2 | 00 byte, 01 word, 1x dword |
| acc_wr | input | 1 | Access is a write |
| phys_addr | output | 24 | Translated physical address (meaningful on hit) |
| hit | output | 1 | Access served by DRAM |
| wr_en | output | 1 | DRAM write enable |
| rd_blank | output | 1 | Read beyond installed memory, return fill pattern |
| blank_data | output | 32 | All-ones fill at the access width |
| cfg_err | output | 1 | Captured code pair is invalid |

## Verification
Range suppression and write protection can both apply to one access: a write to segment 0xFE with protection on, while installed memory is set smaller than the aliased physical segment 0x0E. The bench provokes this by loading such a configuration and issuing that write, then expects no hit, no write enable and no blank, and separately confirms that each condition alone gives its own result. It likewise pairs the high-region alias with out-of-range reads to check that the fill pattern follows the access width.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int OFF_W   = 16;
    localparam int SEG_W   = 8;
    localparam int ADDR_W  = SEG_W + OFF_W;
    localparam int PSEG_W  = SEG_W + 1;
    localparam int SEGS_4M = 1 << (22 - OFF_W);
    localparam int SEGS_1M = 1 << (20 - OFF_W);

    typedef enum logic [1:0] {
        BASE_640 = 2'b00,
        BASE_BAD = 2'b01,
        BASE_512 = 2'b10,
        BASE_256 = 2'b11
    } base_code_e;

    typedef enum logic [1:0] {
        BANK_OFF = 2'b00,
        BANK_4M  = 2'b01,
        BANK_1M  = 2'b10,
        BANK_NIL = 2'b11
    } bank_code_e;

    // segment count held by one bank
    function automatic logic [PSEG_W-1:0] bank_segs(input logic [1:0] code, input logic first);
        logic [PSEG_W-1:0] n;
        case (code)
            BANK_4M: n = PSEG_W'(SEGS_4M);
            BANK_1M: n = PSEG_W'(SEGS_1M);
            default: n = '0;
        endcase
        if (first)
            n = (n >= PSEG_W'(SEGS_1M)) ? n - PSEG_W'(SEGS_1M) : '0;
        return n;
    endfunction

    function automatic logic [SEG_W-1:0] low_last_seg(input logic [1:0] base);
        case (base)
            BASE_640: return SEG_W'(9);
            BASE_512: return SEG_W'(7);
            BASE_256: return SEG_W'(3);
            default:  return '0;
        endcase
    endfunction

    function automatic logic [SEG_W-1:0] high_first_seg(input logic [1:0] base, input logic [1:0] sys);
        if (base == BASE_640 || sys == BANK_4M) return SEG_W'(8'hFA);
        else if (base == BASE_512)               return SEG_W'(8'hF8);
        else                                     return SEG_W'(8'hF4);
    endfunction

    function automatic logic combo_ok(input logic [1:0] base, input logic [1:0] sys);
        return (base != BASE_BAD) && (sys == BANK_4M || sys == BANK_1M);
    endfunction

    function automatic logic [31:0] fill_of(input logic [1:0] size);
        case (size)
            2'b00:   return 32'h0000_00FF;
            2'b01:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/memwin_cfg.sv
module memwin_cfg
    import memwin_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [1:0]                    base_code,
    input  logic [2*NBANK-1:0]            bank_codes,
    input  logic [SEG_W*NBANK-1:0]        win_vbase,
    input  logic                          relo_ram,
    input  logic                          wp,
    input  logic [PSEG_W-1:0]             mem_segs,
    output logic                          enable,
    output logic                          err,
    output logic [SEG_W-1:0]              low_last,
    output logic [SEG_W-1:0]              high_first,
    output logic                          relo_q,
    output logic                          wp_q,
    output logic [PSEG_W-1:0]             mem_q,
    output logic [NBANK-1:0][SEG_W-1:0]   vbase_q,
    output logic [NBANK-1:0][PSEG_W-1:0]  size_o,
    output logic [NBANK-1:0][PSEG_W-1:0]  pbase_o
);

    logic               loaded;
    logic [1:0]         base_q;
    logic [2*NBANK-1:0] codes_q;
    logic               ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded  <= 1'b0;
            base_q  <= '0;
            codes_q <= '0;
            vbase_q <= '0;
            relo_q  <= 1'b0;
            wp_q    <= 1'b0;
            mem_q   <= '0;
        end else if (load) begin
            loaded  <= 1'b1;
            base_q  <= base_code;
            codes_q <= bank_codes;
            vbase_q <= win_vbase;
            relo_q  <= relo_ram;
            wp_q    <= wp;
            mem_q   <= mem_segs;
        end
    end

    assign ok         = combo_ok(base_q, codes_q[1:0]);
    assign enable     = loaded & ok;
    assign err        = loaded & ~ok;
    assign low_last   = low_last_seg(base_q);
    assign high_first = high_first_seg(base_q, codes_q[1:0]);

    // physical start segments accumulate upward from the first megabyte
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign size_o[b] = bank_segs(codes_q[2*b +: 2], 1'(b == 0));
        if (b == 0) begin : g_first
            assign pbase_o[b] = PSEG_W'(SEGS_1M);
        end else begin : g_next
            assign pbase_o[b] = pbase_o[b-1] + size_o[b-1];
        end
    end

    // R8: nothing is mapped directly after reset
    a_r8_reset_unmapped: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!enable && !err));

    // R8: captured configuration holds without a load
    a_r8_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst)) |-> ($stable(codes_q) && $stable(base_q) && $stable(mem_q)));

endmodule

// File: rtl/memwin_window.sv
module memwin_window
    import memwin_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [SEG_W-1:0]  vbase,
    input  logic [PSEG_W-1:0] size,
    input  logic [PSEG_W-1:0] pbase,
    output logic              match,
    output logic [PSEG_W-1:0] pseg
);

    logic [PSEG_W:0] win_end;

    assign win_end = (PSEG_W+1)'(vbase) + (PSEG_W+1)'(size);
    assign match   = (size != '0) && (seg >= vbase) && ((PSEG_W+1)'(seg) < win_end);
    assign pseg    = PSEG_W'(seg) - PSEG_W'(vbase) + pbase;

endmodule

// File: rtl/memwin_xlate.sv
module memwin_xlate
    import memwin_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_load,
    input  logic [1:0]             cfg_base_code,
    input  logic [2*NBANK-1:0]     cfg_bank_codes,
    input  logic [8*NBANK-1:0]     cfg_win_vbase,
    input  logic                   cfg_relo_ram,
    input  logic                   cfg_wp,
    input  logic [8:0]             cfg_mem_segs,
    input  logic                   acc_valid,
    input  logic [23:0]            acc_addr,
    input  logic [1:0]             acc_size,
    input  logic                   acc_wr,
    output logic [23:0]            phys_addr,
    output logic                   hit,
    output logic                   wr_en,
    output logic                   rd_blank,
    output logic [31:0]            blank_data,
    output logic                   cfg_err
);

    logic                         enable;
    logic [SEG_W-1:0]             low_last;
    logic [SEG_W-1:0]             high_first;
    logic                         relo_q;
    logic                         wp_q;
    logic [PSEG_W-1:0]            mem_q;
    logic [NBANK-1:0][SEG_W-1:0]  vbase_q;
    logic [NBANK-1:0][PSEG_W-1:0] size_w;
    logic [NBANK-1:0][PSEG_W-1:0] pbase_w;
    logic [NBANK-1:0]             win_match;
    logic [NBANK-1:0][PSEG_W-1:0] win_pseg;

    logic [SEG_W-1:0]  seg;
    logic [OFF_W-1:0]  off;
    logic              mapped;
    logic [PSEG_W-1:0] pseg;
    logic              in_range;
    logic              prot_seg;

    memwin_cfg #(.NBANK(NBANK)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .base_code  (cfg_base_code),
        .bank_codes (cfg_bank_codes),
        .win_vbase  (cfg_win_vbase),
        .relo_ram   (cfg_relo_ram),
        .wp         (cfg_wp),
        .mem_segs   (cfg_mem_segs),
        .enable     (enable),
        .err        (cfg_err),
        .low_last   (low_last),
        .high_first (high_first),
        .relo_q     (relo_q),
        .wp_q       (wp_q),
        .mem_q      (mem_q),
        .vbase_q    (vbase_q),
        .size_o     (size_w),
        .pbase_o    (pbase_w)
    );

    assign seg = acc_addr[ADDR_W-1:OFF_W];
    assign off = acc_addr[OFF_W-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_win
        memwin_window u_win (
            .seg   (seg),
            .vbase (vbase_q[b]),
            .size  (size_w[b]),
            .pbase (pbase_w[b]),
            .match (win_match[b]),
            .pseg  (win_pseg[b])
        );
    end

    // fixed regions first, then windows in ascending index
    always_comb begin
        mapped = 1'b0;
        pseg   = '0;
        if (enable) begin
            if (seg <= low_last) begin
                mapped = 1'b1;
                pseg   = PSEG_W'(seg);
            end else if (relo_q && seg[SEG_W-1:1] == 7'h07) begin
                mapped = 1'b1;
                pseg   = PSEG_W'(seg);
            end else if (seg >= high_first) begin
                mapped = 1'b1;
                pseg   = PSEG_W'(seg[3:0]);
            end else begin
                for (int b = 0; b < NBANK; b++) begin
                    if (!mapped && win_match[b]) begin
                        mapped = 1'b1;
                        pseg   = win_pseg[b];
                    end
                end
            end
        end
    end

    assign in_range   = pseg < mem_q;
    assign prot_seg   = wp_q && (seg[SEG_W-1:1] == 7'h07 || seg[SEG_W-1:1] == 7'h7F);
    assign hit        = acc_valid & mapped & in_range;
    assign wr_en      = hit & acc_wr & ~prot_seg;
    assign rd_blank   = acc_valid & mapped & ~acc_wr & ~in_range;
    assign blank_data = rd_blank ? fill_of(acc_size) : 32'h0;
    assign phys_addr  = {pseg[SEG_W-1:0], off};

    // R6: a write enable requires a hitting write
    a_r6_wr_needs_hit: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (hit && acc_wr));

    // R6: protected top segments never receive a write enable
    a_r6_top_protected: assert property (@(posedge clk) disable iff (rst)
        (wp_q && acc_addr[23:17] == 7'h7F) |-> !wr_en);

    // R7: invalid configuration serves nothing
    a_r7_err_silences: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!hit && !rd_blank));

    // R5: hit and blank fill are exclusive
    a_r5_hit_or_blank: assert property (@(posedge clk) disable iff (rst)
        !(hit && rd_blank));

    // R1: segments 0..3 are identity in every valid base code
    a_r1_low_identity: assert property (@(posedge clk) disable iff (rst)
        (hit && acc_addr[23:18] == 6'h00) |-> (phys_addr == acc_addr));

endmodule

// File: tb/memwin_xlate_test.sv
module memwin_xlate_test;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [1:0]    cfg_base_code = 2'b00;
    logic [2*NB-1:0] cfg_bank_codes = '0;
    logic [8*NB-1:0] cfg_win_vbase = '0;
    logic          cfg_relo_ram = 1'b0;
    logic          cfg_wp = 1'b0;
    logic [8:0]    cfg_mem_segs = '0;
    logic          acc_valid = 1'b0;
    logic [23:0]   acc_addr = '0;
    logic [1:0]    acc_size = '0;
    logic          acc_wr = 1'b0;
    logic [23:0]   phys_addr;
    logic          hit, wr_en, rd_blank, cfg_err;
    logic [31:0]   blank_data;

    memwin_xlate #(.NBANK(NB)) uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base_code(cfg_base_code),
        .cfg_bank_codes(cfg_bank_codes), .cfg_win_vbase(cfg_win_vbase),
        .cfg_relo_ram(cfg_relo_ram), .cfg_wp(cfg_wp), .cfg_mem_segs(cfg_mem_segs),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size), .acc_wr(acc_wr),
        .phys_addr(phys_addr), .hit(hit), .wr_en(wr_en), .rd_blank(rd_blank),
        .blank_data(blank_data), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic        hit;
        logic        wr;
        logic        blank;
        logic        err;
        logic [23:0] phys;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: last captured configuration
    bit          m_loaded = 1'b0;
    logic [1:0]  m_base;
    logic [7:0]  m_codes;
    logic [31:0] m_vb;
    bit          m_relo, m_wp;
    int          m_mem;

    function automatic exp_t model(input logic [23:0] a, input logic [1:0] sz, input bit wr, input string req);
        exp_t e;
        int seg, low, hf, acc, psg;
        bit ok, mp;
        seg = int'(a[23:16]);
        ok  = (m_base != 2'b01) && (m_codes[1:0] == 2'b01 || m_codes[1:0] == 2'b10);
        low = (m_base == 2'b00) ? 9 : (m_base == 2'b10) ? 7 : 3;
        if (m_base == 2'b00 || m_codes[1:0] == 2'b01) hf = 'hFA;
        else if (m_base == 2'b10) hf = 'hF8;
        else hf = 'hF4;
        mp = 0; psg = 0;
        if (m_loaded && ok) begin
            if (seg <= low) begin mp = 1; psg = seg; end
            else if (m_relo && (seg == 'h0E || seg == 'h0F)) begin mp = 1; psg = seg; end
            else if (seg >= hf) begin mp = 1; psg = seg % 16; end
            else begin
                acc = 16;
                for (int i = 0; i < NB; i++) begin
                    int n, vb;
                    n  = (m_codes[2*i +: 2] == 2'b01) ? 64 : (m_codes[2*i +: 2] == 2'b10) ? 16 : 0;
                    if (i == 0) n = (n >= 16) ? n - 16 : 0;
                    vb = int'(m_vb[8*i +: 8]);
                    if (!mp && n > 0 && seg >= vb && seg < vb + n) begin
                        mp = 1; psg = seg - vb + acc;
                    end
                    acc += n;
                end
            end
        end
        e.err   = m_loaded && !ok;
        e.hit   = mp && psg < m_mem;
        e.wr    = e.hit && wr && !(m_wp && (seg == 'h0E || seg == 'h0F || seg == 'hFE || seg == 'hFF));
        e.blank = mp && !wr && psg >= m_mem;
        e.data  = !e.blank ? 32'h0 : (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
        e.phys  = {psg[7:0], a[15:0]};
        e.req   = req;
        return e;
    endfunction

    task automatic access(input logic [23:0] a, input logic [1:0] sz, input bit wr, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_wr = wr; cfg_load = 1'b0;
        q.push_back(model(a, sz, wr, req));
    endtask

    task automatic configure(input logic [1:0] base, input logic [7:0] codes, input logic [31:0] vb,
                             input bit relo, input bit wp, input int mem);
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_base_code = base; cfg_bank_codes = codes; cfg_win_vbase = vb;
        cfg_relo_ram = relo; cfg_wp = wp; cfg_mem_segs = 9'(mem);
        cfg_load = 1'b1;
        m_loaded = 1; m_base = base; m_codes = codes; m_vb = vb; m_relo = relo; m_wp = wp; m_mem = mem;
    endtask

    // monitor: compares after the outputs settle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (hit !== e.hit || wr_en !== e.wr || rd_blank !== e.blank || cfg_err !== e.err ||
                    blank_data !== e.data || (e.hit && phys_addr !== e.phys)) begin
                    errors++;
                    $display("FAIL %s addr=%h: got hit=%b wr=%b blank=%b err=%b phys=%h data=%h, exp hit=%b wr=%b blank=%b err=%b phys=%h data=%h",
                             e.req, acc_addr, hit, wr_en, rd_blank, cfg_err, phys_addr, blank_data,
                             e.hit, e.wr, e.blank, e.err, e.phys, e.data);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        access(24'h00_0100, 2'b00, 0, "R8 reset");
        access(24'hFF_0000, 2'b00, 0, "R8 reset");
        @(negedge clk);
        rst = 1'b0;
        access(24'h00_0100, 2'b10, 0, "R8 after reset");

        // 640 KB base, bank0 4MB at 0x10, bank1 1MB at 0x40, bank2 4MB at 0x60
        configure(2'b00, 8'b11_01_10_01, {8'h00, 8'h60, 8'h40, 8'h10}, 1, 1, 'h80);
        access(24'h09_1234, 2'b00, 0, "R1 640 top");
        access(24'h0A_0000, 2'b00, 0, "R1 640 edge");
        access(24'h0E_8000, 2'b01, 0, "R3 relo read");
        access(24'h0F_0002, 2'b01, 1, "R6 relo protected");
        access(24'hFA_0010, 2'b10, 0, "R2 alias FA");
        access(24'hF9_0000, 2'b00, 0, "R2 below start");
        access(24'hFF_FFFE, 2'b01, 1, "R6 top protected");
        access(24'h10_0000, 2'b10, 0, "R4 bank0 start");
        access(24'h3F_FFFF, 2'b00, 1, "R4 bank0 end write");
        access(24'h40_0004, 2'b10, 0, "R4 bank1");
        access(24'h50_0000, 2'b00, 0, "R4 gap");
        access(24'h60_1234, 2'b01, 0, "R4 bank2");
        access(24'h8F_FFFF, 2'b00, 0, "R5 last in range");
        access(24'h90_0000, 2'b00, 0, "R5 blank byte");
        access(24'h9A_0000, 2'b01, 0, "R5 blank word");
        access(24'h9F_FFFC, 2'b10, 0, "R5 blank dword");
        access(24'h95_0000, 2'b11, 1, "R5 write beyond");
        acc_valid = 1'b1;

        // 256 KB base, 1MB system, relocation off, no protection
        configure(2'b11, 8'b11_11_11_10, 32'h0, 0, 0, 'h20);
        access(24'h03_FFFF, 2'b00, 0, "R1 256 top");
        access(24'h04_0000, 2'b00, 0, "R1 256 edge");
        access(24'hF4_0008, 2'b00, 0, "R2 alias F4");
        access(24'hF3_0000, 2'b00, 0, "R2 below F4");
        access(24'h0E_0000, 2'b00, 0, "R3 relo off");
        access(24'hFE_0000, 2'b00, 1, "R6 unprotected write");
        access(24'h00_0000, 2'b00, 0, "R4 bank0 1MB empty");

        // 512 KB base with 4MB then 1MB system RAM
        configure(2'b10, 8'b11_11_11_01, 32'h0000_0010, 0, 0, 'h100);
        access(24'h07_0000, 2'b00, 0, "R1 512 top");
        access(24'h08_0000, 2'b00, 0, "R1 512 edge");
        access(24'hF8_0000, 2'b00, 0, "R2 512/4M F8");
        configure(2'b10, 8'b11_11_11_10, 32'h0, 0, 0, 'h100);
        access(24'hF8_0000, 2'b00, 0, "R2 512/1M F8");
        access(24'hF7_0000, 2'b00, 0, "R2 512/1M F7");

        // invalid codes
        configure(2'b01, 8'b11_11_11_01, 32'h0, 1, 0, 'h100);
        access(24'h00_0000, 2'b00, 0, "R7 bad base");
        access(24'hFF_0000, 2'b00, 0, "R7 bad base high");
        // inputs change without a load: map must not follow
        @(negedge clk);
        cfg_base_code = 2'b00;
        access(24'h00_0000, 2'b00, 0, "R8 no load");
        configure(2'b00, 8'b11_11_11_11, 32'h0, 0, 0, 'h100);
        access(24'h00_0000, 2'b00, 0, "R7 bad sys");

        // overlapping windows and window over low memory
        configure(2'b00, 8'b11_11_01_01, {8'h00, 8'h00, 8'h10, 8'h00}, 0, 0, 'h100);
        access(24'h05_0000, 2'b00, 0, "R9 low wins");
        access(24'h20_0000, 2'b00, 0, "R9 bank0 wins");
        access(24'h30_0000, 2'b00, 0, "R9 bank1 beyond bank0");
        access(24'hFB_0000, 2'b00, 0, "R9 high over window");

        // protection and range suppression at once
        configure(2'b00, 8'b11_11_11_01, 32'h0, 1, 1, 'h0C);
        access(24'hFE_0000, 2'b00, 1, "R6 R5 protected beyond");
        access(24'hFE_0000, 2'b01, 0, "R5 alias beyond read");
        access(24'hFB_0000, 2'b00, 1, "R5 alias in range write");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule